// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which interrupt a small 8-bit CPU core services next. It watches an asynchronous active-low external request line, an optional port request that can be folded into it, three timer status flags with one enable bit each, and a software-interrupt strobe from the instruction decoder. It also holds the CPU's interrupt mask bit, which the CPU changes through set, clear and return-from-interrupt strobes. Requests are only evaluated when the CPU signals that an instruction has completed. Hardware requests that arrive mid-instruction are held until that point.

When a request wins at an instruction boundary, the block pulses a stacking request to the CPU and sets the mask. It then presents the two byte addresses of the winning vector on two consecutive cycles, high byte first, each with a valid strobe. Reset behaves like the top-priority source: on leaving reset the block fetches the reset vector and the mask starts set. Priority follows the vector address order: reset first, then software, then external/port, then timer.

Top module: `irq_vector_ctrl`

## Requirements
- R1: During reset `vec_valid` and `stack_req` are 0 and `mask_o` is 1. On the first two cycles after reset is released, `vec_valid` is 1 with `vec_addr` 0x1FFE and then 0x1FFF, `vec_src` 0 (reset) and no stack request. The next cycle is idle.
- R2: Every vector fetch is exactly two valid cycles: the even base address, then base+1, then `vec_valid` returns to 0.
- R3: A software request (`swi_req` together with `insn_done`, or latched earlier) is taken at the boundary whatever the mask. It fetches 0x1FFC with `vec_src` 1.
- R4: A falling edge on `ext_irq_n` passes a two-flop synchronizer and is latched as pending. With the mask clear and `irq_en` set it is taken at the next boundary, fetching 0x1FFA with `vec_src` 2. Taking it clears the pending state. With `irq_en` clear it is not taken.
- R5: Timer flag bit 0 (capture), bit 1 (compare) and bit 2 (overflow) each request vector 0x1FF8 (`vec_src` 3) only when the matching `tmr_ie` bit is set. A flag whose enable is clear requests nothing.
- R6: When several requests are eligible, software beats external, and external beats timer.
- R7: With the mask set, external and timer requests are not taken. A pending external edge is kept and is taken once the mask is cleared.
- R8: A request is taken only in a cycle after `insn_done` was high. With no `insn_done`, no stack request appears however long a request is present.
- R9: Taking an interrupt pulses `stack_req` for exactly one cycle, aligned with the high-byte fetch, and `mask_o` is 1 from that cycle on.
- R10: With `port_irq_en` set, a falling edge on `port_irq_n` acts as an external request. With it clear, the port line has no effect.
- R11: Reset discards a latched software request and a pending external edge.
- R12: `cli_req` clears the mask and `sei_req` sets it. `rti_req` loads `rti_mask` and overrides both. Taking an interrupt overrides all three.
- R13: `insn_done` during a vector fetch starts no new fetch. A `swi_req` seen then is latched for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 1 | Asynchronous external request, falling-edge active |
| port_irq_n | input | 1 | Asynchronous port request, falling-edge active |
| port_irq_en | input | 1 | Merges the port request into the external request |
| irq_en | input | 1 | Enable for the external/port request |
| tmr_flag | input | 3 | Timer flags: [0] capture, [1] compare, [2] overflow |
| tmr_ie | input | 3 | Per-flag timer enables, same bit order |
| swi_req | input | 1 | Software-interrupt strobe from the decoder |
| insn_done | input | 1 | Instruction-complete strobe |
| cli_req | input | 1 | Clear-mask strobe |
| sei_req | input | 1 | Set-mask strobe |
| rti_req | input | 1 | Return-from-interrupt strobe |
| rti_mask | input | 1 | Mask value restored by `rti_req` |
| stack_req | output | 1 | One-cycle request to stack CPU state |
| vec_valid | output | 1 | Vector fetch address valid |
| vec_addr | output | 16 | Vector fetch byte address |
| vec_src | output | 2 | Source being fetched: 0 reset, 1 software, 2 external, 3 timer |
| mask_o | output | 1 | Current interrupt mask bit |

## Verification
The assertions take for granted that every synchronous strobe is driven from the clock domain and that the CPU does not depend on `insn_done` during a fetch. They also assume the asynchronous request lines stay low for several cycles. The stimulus changes every synchronous input half a period away from the active edge. It holds each request line low for at least five cycles before it pulses `insn_done`, so the synchronizer latency never decides a result. It only changes `port_irq_en` while both request lines are high, so switching the merge never creates an edge on its own.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h1FF8,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TMR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq_n,
  input  logic              port_irq_n,
  input  logic              port_irq_en,
  input  logic              irq_en,
  input  logic [NUM_TMR-1:0] tmr_flag,
  input  logic [NUM_TMR-1:0] tmr_ie,
  input  logic              swi_req,
  input  logic              insn_done,
  input  logic              cli_req,
  input  logic              sei_req,
  input  logic              rti_req,
  input  logic              rti_mask,
  output logic              stack_req,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [1:0]        vec_src,
  output logic              mask_o
);

  localparam logic [1:0] SRC_RST = 2'd0;
  localparam logic [1:0] SRC_SWI = 2'd1;
  localparam logic [1:0] SRC_IRQ = 2'd2;
  localparam logic [1:0] SRC_TMR = 2'd3;

  typedef enum logic [1:0] {ST_BOOT, ST_IDLE, ST_HI, ST_LO} state_t;

  state_t               state;
  logic [1:0]           src_q;
  logic                 mask_q;
  logic                 swi_pend;
  logic                 irq_pend;
  logic [SYNC_STAGES:0] irq_sync;

  wire merged_n  = ext_irq_n & (port_irq_n | ~port_irq_en);
  wire irq_fall  = irq_sync[SYNC_STAGES] & ~irq_sync[SYNC_STAGES-1];
  wire tmr_req   = |(tmr_flag & tmr_ie);
  wire boundary  = insn_done && (state == ST_IDLE);
  wire swi_now   = swi_pend | swi_req;
  wire irq_ok    = ~mask_q & irq_en & irq_pend;
  wire pick_swi  = swi_now;
  wire pick_irq  = ~swi_now & irq_ok;
  wire pick_tmr  = ~swi_now & ~irq_ok & ~mask_q & tmr_req;
  wire take      = boundary & (pick_swi | pick_irq | pick_tmr);
  wire [1:0] pick_src = pick_swi ? SRC_SWI : (pick_irq ? SRC_IRQ : SRC_TMR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_sync <= '1;
    else        irq_sync <= {irq_sync[SYNC_STAGES-1:0], merged_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_pend <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      swi_pend <= (swi_pend | swi_req) & ~(take & pick_swi);
      irq_pend <= (irq_pend & ~(take & pick_irq)) | irq_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 1'b1;
    else if (take)    mask_q <= 1'b1;
    else if (rti_req) mask_q <= rti_mask;
    else if (sei_req) mask_q <= 1'b1;
    else if (cli_req) mask_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      src_q     <= SRC_RST;
      stack_req <= 1'b0;
    end else begin
      stack_req <= take;
      case (state)
        ST_BOOT: begin
          state <= ST_HI;
          src_q <= SRC_RST;
        end
        ST_IDLE: if (take) begin
          state <= ST_HI;
          src_q <= pick_src;
        end
        ST_HI:   state <= ST_LO;
        default: state <= ST_IDLE;
      endcase
    end
  end

  wire [ADDR_W-1:0] vec_base = VEC_BASE + ADDR_W'({~src_q, 1'b0});

  assign vec_valid = (state == ST_HI) || (state == ST_LO);
  assign vec_addr  = vec_base | ADDR_W'(state == ST_LO);
  assign vec_src   = src_q;
  assign mask_o    = mask_q;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done,
  input logic              stack_req,
  input logic              vec_valid,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [1:0]        vec_src,
  input logic              mask_o
);

  a_r2_lo_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_addr[0] |=> vec_valid && vec_addr[0] &&
      vec_addr[ADDR_W-1:1] == $past(vec_addr[ADDR_W-1:1]));

  a_r2_fetch_ends: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_addr[0] |=> !vec_valid);

  a_r9_stack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stack_req |=> !stack_req);

  a_r9_stack_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    stack_req |-> vec_valid && !vec_addr[0] && mask_o);

  a_r8_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    stack_req |-> $past(insn_done));

  a_r7_hw_needs_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    stack_req && vec_src[1] |-> !$past(mask_o));

  a_r3_swi_address: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_src == 2'd1 && !vec_addr[0] |-> vec_addr[2:0] == 3'b100);

  a_r1_boot_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_src == 2'd0 |-> mask_o && !stack_req && vec_addr[2:1] == 2'b11);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .stack_req(stack_req),
  .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_src(vec_src), .mask_o(mask_o)
);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ext_irq_n, port_irq_n, port_irq_en, irq_en;
  logic [2:0] tmr_flag, tmr_ie;
  logic swi_req, insn_done, cli_req, sei_req, rti_req, rti_mask;
  logic stack_req, vec_valid, mask_o;
  logic [15:0] vec_addr;
  logic [1:0] vec_src;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .port_irq_n(port_irq_n),
    .port_irq_en(port_irq_en), .irq_en(irq_en), .tmr_flag(tmr_flag), .tmr_ie(tmr_ie),
    .swi_req(swi_req), .insn_done(insn_done), .cli_req(cli_req), .sei_req(sei_req),
    .rti_req(rti_req), .rti_mask(rti_mask), .stack_req(stack_req), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .vec_src(vec_src), .mask_o(mask_o)
  );

  int n_checks = 0;
  int n_fail = 0;

  // row: [28]mask [27]swi [26]irq edge [25]irq_en [24:22]flags [21:19]ie [18]take [17:16]src [15:0]base
  localparam int NROWS = 12;
  localparam logic [28:0] ROWS [NROWS] = '{
    {1'b1,1'b1,1'b0,1'b0,3'b000,3'b000,1'b1,2'd1,16'h1FFC}, // R3 masked swi
    {1'b0,1'b1,1'b0,1'b0,3'b000,3'b000,1'b1,2'd1,16'h1FFC}, // R3
    {1'b0,1'b0,1'b1,1'b1,3'b000,3'b000,1'b1,2'd2,16'h1FFA}, // R4
    {1'b0,1'b0,1'b1,1'b0,3'b000,3'b000,1'b0,2'd0,16'h0000}, // R4 disabled
    {1'b0,1'b0,1'b0,1'b0,3'b001,3'b001,1'b1,2'd3,16'h1FF8}, // R5 capture
    {1'b0,1'b0,1'b0,1'b0,3'b010,3'b010,1'b1,2'd3,16'h1FF8}, // R5 compare
    {1'b0,1'b0,1'b0,1'b0,3'b100,3'b100,1'b1,2'd3,16'h1FF8}, // R5 overflow
    {1'b0,1'b0,1'b0,1'b0,3'b111,3'b000,1'b0,2'd0,16'h0000}, // R5 no enables
    {1'b0,1'b1,1'b1,1'b1,3'b111,3'b111,1'b1,2'd1,16'h1FFC}, // R6 swi first
    {1'b0,1'b0,1'b1,1'b1,3'b010,3'b010,1'b1,2'd2,16'h1FFA}, // R6 irq over timer
    {1'b1,1'b0,1'b1,1'b1,3'b111,3'b111,1'b0,2'd0,16'h0000}, // R7 masked
    {1'b1,1'b1,1'b0,1'b0,3'b001,3'b001,1'b1,2'd1,16'h1FFC}  // R3 over masked timer
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic idle_inputs();
    ext_irq_n = 1'b1; port_irq_n = 1'b1; port_irq_en = 1'b0; irq_en = 1'b0;
    tmr_flag = '0; tmr_ie = '0; swi_req = 1'b0; insn_done = 1'b0;
    cli_req = 1'b0; sei_req = 1'b0; rti_req = 1'b0; rti_mask = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic clear_mask();
    cli_req = 1'b1; tick(); cli_req = 1'b0;
  endtask

  task automatic boundary();
    insn_done = 1'b1; tick(); insn_done = 1'b0; swi_req = 1'b0;
  endtask

  task automatic expect_take(input string req, input logic [15:0] base, input logic [1:0] src);
    chk(req, {stack_req, vec_valid, mask_o}, 3'b111);
    chk(req, vec_addr, base);
    chk(req, vec_src, src);
    tick();
    chk(req, {stack_req, vec_valid, vec_addr}, {2'b01, base | 16'h1});
    tick();
    chk(req, {stack_req, vec_valid}, 2'b00);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) tick();
    // R1 reset state and boot fetch
    chk("R1 in reset", {vec_valid, stack_req, mask_o}, 3'b001);
    rst_n = 1'b1;
    tick();
    chk("R1 boot hi", {vec_valid, stack_req, vec_src, vec_addr}, {2'b10, 2'd0, 16'h1FFE});
    tick();
    chk("R2 boot lo", {vec_valid, vec_addr}, {1'b1, 16'h1FFF});
    tick();
    chk("R2 boot ends", {vec_valid, mask_o}, 2'b01);

    for (int i = 0; i < NROWS; i++) begin
      logic [28:0] r;
      r = ROWS[i];
      do_reset();
      if (!r[28]) clear_mask();
      irq_en = r[25]; tmr_flag = r[24:22]; tmr_ie = r[21:19];
      if (r[26]) begin
        ext_irq_n = 1'b0;
        repeat (5) tick();
      end
      swi_req = r[27];
      boundary();
      if (r[18]) expect_take($sformatf("R%0d row %0d", r[27] ? 3 : (r[26] ? 4 : 5), i), r[15:0], r[17:16]);
      else chk($sformatf("R7 no take row %0d", i), {stack_req, vec_valid}, 2'b00);
      ext_irq_n = 1'b1;
    end

    // R7 pending edge survives mask
    do_reset();
    irq_en = 1'b1; ext_irq_n = 1'b0; repeat (5) tick(); ext_irq_n = 1'b1;
    boundary();
    chk("R7 masked", {stack_req, vec_valid}, 2'b00);
    clear_mask();
    boundary();
    expect_take("R7 kept", 16'h1FFA, 2'd2);
    boundary();
    chk("R4 pending cleared", {stack_req, vec_valid}, 2'b00);

    // R8 no boundary, no take
    do_reset();
    clear_mask();
    tmr_flag = 3'b100; tmr_ie = 3'b100;
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < 6; k++) begin tick(); seen = seen | stack_req | vec_valid; end
      chk("R8 waits for boundary", seen, 1'b0);
    end
    boundary();
    expect_take("R8 at boundary", 16'h1FF8, 2'd3);

    // R10 port merge
    do_reset();
    clear_mask();
    irq_en = 1'b1; port_irq_en = 1'b1; port_irq_n = 1'b0;
    repeat (5) tick();
    boundary();
    expect_take("R10 port merged", 16'h1FFA, 2'd2);
    do_reset();
    clear_mask();
    irq_en = 1'b1; port_irq_n = 1'b0;
    repeat (5) tick();
    boundary();
    chk("R10 port ignored", {stack_req, vec_valid}, 2'b00);

    // R11 reset discards pending
    do_reset();
    clear_mask();
    swi_req = 1'b1; tick(); swi_req = 1'b0;
    ext_irq_n = 1'b0; repeat (5) tick(); ext_irq_n = 1'b1;
    do_reset();
    clear_mask();
    irq_en = 1'b1;
    boundary();
    chk("R11 pending discarded", {stack_req, vec_valid}, 2'b00);

    // R12 mask control
    do_reset();
    clear_mask();
    chk("R12 cli", mask_o, 1'b0);
    sei_req = 1'b1; tick(); sei_req = 1'b0;
    chk("R12 sei", mask_o, 1'b1);
    rti_req = 1'b1; rti_mask = 1'b0; sei_req = 1'b1; tick(); rti_req = 1'b0; sei_req = 1'b0;
    chk("R12 rti over sei", mask_o, 1'b0);
    rti_req = 1'b1; rti_mask = 1'b1; cli_req = 1'b1; tick(); rti_req = 1'b0; cli_req = 1'b0;
    chk("R12 rti over cli", mask_o, 1'b1);
    clear_mask();
    swi_req = 1'b1; cli_req = 1'b1; insn_done = 1'b1; tick();
    swi_req = 1'b0; cli_req = 1'b0; insn_done = 1'b0;
    chk("R12 take over cli", {mask_o, stack_req}, 2'b11);
    repeat (2) tick();

    // R13 boundary during fetch ignored, swi latched
    do_reset();
    swi_req = 1'b1; boundary();
    chk("R13 first take", {stack_req, vec_addr}, {1'b1, 16'h1FFC});
    swi_req = 1'b1; insn_done = 1'b1; tick(); swi_req = 1'b0; insn_done = 1'b0;
    chk("R13 fetch continues", {stack_req, vec_valid, vec_addr}, {2'b01, 16'h1FFD});
    tick();
    chk("R13 no new fetch", {stack_req, vec_valid}, 2'b00);
    tick();
    chk("R13 still idle", {stack_req, vec_valid}, 2'b00);
    boundary();
    expect_take("R13 latched swi", 16'h1FFC, 2'd1);

    finish_run();
  end

endmodule